// File: doc/BRIEF.md
# Linked Control-Block Slot List Manager

This block keeps track of which command control-block slots belong to which of three lists: a waiting list of slots queued for selection, a free list of slots available for reuse, and a disconnected list of slots whose transaction is suspended. Slots live in an on-chip slot store. Each slot holds a next link, a prev link and a tag byte. Each list is anchored by a head register. The all-ones index is reserved as the null link, so with the default 8-bit index the slots are 0x00 to 0xFE.

A client issues one command at a time on a request port. An accepted command raises `busy` until it has finished. The command then ends with a single-cycle `done` pulse that carries the affected slot index, or null, on `result`. The waiting and free lists are singly linked and support push-to-head and pop-head. The disconnected list is doubly linked. Any member can be unlinked from it in constant time, and the neighbours' links and the head are patched as part of the unlink. A grant command takes a slot from the free list first and from the disconnected list second.

Top module: `slot_list_mgr`

## Requirements
- R1: After reset, `wait_head`, `free_head` and `disc_head` all read null (all ones), and `busy` and `done` are low.
- R2: A request is taken only when `busy` is low. `busy` is high from the cycle after acceptance until `done`. `done` is high for exactly one cycle, with `result` valid. Any request presented while `busy` is high is ignored.
- R3: Wait push (op 0) makes `req_slot` the waiting head, and the former head follows it. Pops therefore return slots in last-in, first-out order. `result` is the slot.
- R4: Wait pop (op 1) returns the waiting head and advances the head to that slot's successor. On an empty list it returns null and leaves every head unchanged.
- R5: Free push (op 2) makes the slot the free head and overwrites its tag byte with null.
- R6: Grant (op 5) returns and removes the free head if the free list is non-empty. Otherwise it returns and unlinks the disconnected head. Otherwise it returns null.
- R7: Disconnected push (op 3) makes the slot the disconnected head, ahead of the previous members.
- R8: Disconnected drop (op 4) unlinks the named member, whether it is the head, a middle member or the tail. The remaining members keep their relative order, and `result` is the slot.
- R9: Push, drop and tag-write commands whose slot operand is null change no list and no slot, and return null.
- R10: Tag write (op 6) stores `req_data` in the slot's tag byte and returns the slot. Tag read (op 7) returns the slot's tag byte in `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request, sampled while idle |
| req_op | input | 3 | Command code (0 wait push, 1 wait pop, 2 free push, 3 disconnected push, 4 disconnected drop, 5 grant, 6 tag write, 7 tag read) |
| req_slot | input | IDX_W | Slot operand |
| req_data | input | IDX_W | Tag value for tag write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | IDX_W | Slot index, tag byte or null |
| wait_head | output | IDX_W | Waiting list head |
| free_head | output | IDX_W | Free list head |
| disc_head | output | IDX_W | Disconnected list head |

## Verification
The assertions assume that the client keeps the lists well formed. A slot is pushed only while it belongs to no list, and only members of the disconnected list are dropped. The random stimulus keeps to these rules by tracking slot ownership in the bench. It picks a free-standing slot for each push and draws drop operands from the modelled disconnected list. Null operands and requests held during `busy` are applied only in directed cases, where their effect is defined.

// File: rtl/slot_list_pkg.sv
package slot_list_pkg;

   typedef enum logic [2:0] {
      OP_WAIT_PUSH = 3'd0,
      OP_WAIT_POP  = 3'd1,
      OP_FREE_PUSH = 3'd2,
      OP_DISC_PUSH = 3'd3,
      OP_DISC_DROP = 3'd4,
      OP_GRANT     = 3'd5,
      OP_TAG_SET   = 3'd6,
      OP_TAG_GET   = 3'd7
   } slot_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STEP1 = 2'd1,
      ST_STEP2 = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/slot_link_ram.sv
module slot_link_ram #(
   parameter int IDX_W = 8,
   parameter int NRD   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [IDX_W-1:0]     waddr,
   input  logic [IDX_W-1:0]     wdata,
   input  logic [NRD*IDX_W-1:0] raddr,
   output logic [NRD*IDX_W-1:0] rdata
);
   localparam int DEPTH = (1 << IDX_W) - 1;
   localparam logic [IDX_W-1:0] NULL_IDX = {IDX_W{1'b1}};

   logic [IDX_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= NULL_IDX;
      end else if (we && waddr != NULL_IDX) begin
         mem[waddr] <= wdata;
      end
   end

   // the null index has no storage: reading it yields null
   for (genvar g = 0; g < NRD; g++) begin : g_rd
      logic [IDX_W-1:0] a;
      assign a = raddr[g*IDX_W +: IDX_W];
      assign rdata[g*IDX_W +: IDX_W] = (a == NULL_IDX) ? NULL_IDX : mem[a];
   end

   assert_no_null_write_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      we |-> waddr != NULL_IDX);

endmodule

// File: rtl/slot_list_seq.sv
module slot_list_seq
   import slot_list_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [IDX_W-1:0] req_slot,
   input  logic [IDX_W-1:0] req_data,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] result,
   output logic [IDX_W-1:0] wait_head,
   output logic [IDX_W-1:0] free_head,
   output logic [IDX_W-1:0] disc_head,
   // link store access
   output logic             nx_we,
   output logic [IDX_W-1:0] nx_waddr,
   output logic [IDX_W-1:0] nx_wdata,
   output logic [3*IDX_W-1:0] nx_raddr,
   input  logic [3*IDX_W-1:0] nx_rdata,
   output logic             pv_we,
   output logic [IDX_W-1:0] pv_waddr,
   output logic [IDX_W-1:0] pv_wdata,
   output logic [IDX_W-1:0] pv_raddr,
   input  logic [IDX_W-1:0] pv_rdata,
   output logic             tg_we,
   output logic [IDX_W-1:0] tg_waddr,
   output logic [IDX_W-1:0] tg_wdata,
   output logic [IDX_W-1:0] tg_raddr,
   input  logic [IDX_W-1:0] tg_rdata
);
   localparam logic [IDX_W-1:0] NULL_IDX = {IDX_W{1'b1}};

   seq_state_e       state;
   slot_op_e         op_r;
   logic [IDX_W-1:0] slot_r, data_r, res_r;
   logic [IDX_W-1:0] whead, fhead, dhead;
   logic [IDX_W-1:0] nx_slot, nx_whead, nx_fhead;
   logic             slot_ok;

   assign nx_raddr = {fhead, whead, slot_r};
   assign nx_slot  = nx_rdata[0*IDX_W +: IDX_W];
   assign nx_whead = nx_rdata[1*IDX_W +: IDX_W];
   assign nx_fhead = nx_rdata[2*IDX_W +: IDX_W];
   assign pv_raddr = slot_r;
   assign tg_raddr = slot_r;
   assign slot_ok  = (slot_r != NULL_IDX);

   always_comb begin
      nx_we = 1'b0; nx_waddr = slot_r; nx_wdata = NULL_IDX;
      pv_we = 1'b0; pv_waddr = slot_r; pv_wdata = NULL_IDX;
      tg_we = 1'b0; tg_waddr = slot_r; tg_wdata = NULL_IDX;
      if (state == ST_STEP1 && slot_ok) begin
         case (op_r)
            OP_WAIT_PUSH: begin nx_we = 1'b1; nx_wdata = whead; end
            OP_FREE_PUSH: begin nx_we = 1'b1; nx_wdata = fhead; tg_we = 1'b1; end
            OP_DISC_PUSH: begin nx_we = 1'b1; nx_wdata = dhead; pv_we = 1'b1; end
            OP_DISC_DROP: if (nx_slot != NULL_IDX) begin
               pv_we = 1'b1; pv_waddr = nx_slot; pv_wdata = pv_rdata;
            end
            OP_TAG_SET:   begin tg_we = 1'b1; tg_wdata = data_r; end
            default: ;
         endcase
      end else if (state == ST_STEP2) begin
         if (op_r == OP_DISC_PUSH && dhead != NULL_IDX) begin
            pv_we = 1'b1; pv_waddr = dhead; pv_wdata = slot_r;
         end else if (op_r == OP_DISC_DROP && pv_rdata != NULL_IDX) begin
            nx_we = 1'b1; nx_waddr = pv_rdata; nx_wdata = nx_slot;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op_r  <= OP_WAIT_POP;
         slot_r <= NULL_IDX; data_r <= NULL_IDX; res_r <= NULL_IDX;
         whead <= NULL_IDX; fhead <= NULL_IDX; dhead <= NULL_IDX;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               op_r   <= slot_op_e'(req_op);
               slot_r <= req_slot;
               data_r <= req_data;
               state  <= ST_STEP1;
            end
            ST_STEP1: begin
               state <= ST_DONE;
               res_r <= slot_ok ? slot_r : NULL_IDX;
               case (op_r)
                  OP_WAIT_PUSH: if (slot_ok) whead <= slot_r;
                  OP_WAIT_POP: begin
                     res_r <= whead;
                     if (whead != NULL_IDX) whead <= nx_whead;
                  end
                  OP_FREE_PUSH: if (slot_ok) fhead <= slot_r;
                  OP_DISC_PUSH, OP_DISC_DROP: if (slot_ok) state <= ST_STEP2;
                  OP_GRANT: begin
                     if (fhead != NULL_IDX) begin
                        res_r <= fhead;
                        fhead <= nx_fhead;
                     end else if (dhead != NULL_IDX) begin
                        op_r   <= OP_DISC_DROP;
                        slot_r <= dhead;
                        state  <= ST_STEP1;
                     end else begin
                        res_r <= NULL_IDX;
                     end
                  end
                  OP_TAG_GET: res_r <= tg_rdata;
                  default: ;
               endcase
            end
            ST_STEP2: begin
               state <= ST_DONE;
               res_r <= slot_r;
               if (op_r == OP_DISC_PUSH) dhead <= slot_r;
               else if (pv_rdata == NULL_IDX) dhead <= nx_slot;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign result    = res_r;
   assign wait_head = whead;
   assign free_head = fhead;
   assign disc_head = dhead;

   assert_reset_heads_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (wait_head == NULL_IDX && free_head == NULL_IDX && disc_head == NULL_IDX));

   assert_done_pulse_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_start_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |-> $past(req_valid));

   assert_empty_pop_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_r == OP_WAIT_POP && result == NULL_IDX) |-> wait_head == NULL_IDX);

   assert_grant_free_first_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEP1 && op_r == OP_GRANT && fhead != NULL_IDX)
      |=> (done && result == $past(fhead)));

endmodule

// File: rtl/slot_list_mgr.sv
module slot_list_mgr #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [IDX_W-1:0] req_slot,
   input  logic [IDX_W-1:0] req_data,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] result,
   output logic [IDX_W-1:0] wait_head,
   output logic [IDX_W-1:0] free_head,
   output logic [IDX_W-1:0] disc_head
);
   if (IDX_W < 2 || IDX_W > 10) begin : g_bad_width
      $error("slot_list_mgr: IDX_W must lie in 2..10");
   end

   logic               nx_we, pv_we, tg_we;
   logic [IDX_W-1:0]   nx_waddr, nx_wdata, pv_waddr, pv_wdata, tg_waddr, tg_wdata;
   logic [3*IDX_W-1:0] nx_raddr, nx_rdata;
   logic [IDX_W-1:0]   pv_raddr, pv_rdata, tg_raddr, tg_rdata;

   slot_list_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_slot(req_slot), .req_data(req_data),
      .busy(busy), .done(done), .result(result),
      .wait_head(wait_head), .free_head(free_head), .disc_head(disc_head),
      .nx_we(nx_we), .nx_waddr(nx_waddr), .nx_wdata(nx_wdata),
      .nx_raddr(nx_raddr), .nx_rdata(nx_rdata),
      .pv_we(pv_we), .pv_waddr(pv_waddr), .pv_wdata(pv_wdata),
      .pv_raddr(pv_raddr), .pv_rdata(pv_rdata),
      .tg_we(tg_we), .tg_waddr(tg_waddr), .tg_wdata(tg_wdata),
      .tg_raddr(tg_raddr), .tg_rdata(tg_rdata)
   );

   slot_link_ram #(.IDX_W(IDX_W), .NRD(3)) u_next (
      .clk(clk), .rst_n(rst_n), .we(nx_we), .waddr(nx_waddr), .wdata(nx_wdata),
      .raddr(nx_raddr), .rdata(nx_rdata)
   );

   slot_link_ram #(.IDX_W(IDX_W), .NRD(1)) u_prev (
      .clk(clk), .rst_n(rst_n), .we(pv_we), .waddr(pv_waddr), .wdata(pv_wdata),
      .raddr(pv_raddr), .rdata(pv_rdata)
   );

   slot_link_ram #(.IDX_W(IDX_W), .NRD(1)) u_tag (
      .clk(clk), .rst_n(rst_n), .we(tg_we), .waddr(tg_waddr), .wdata(tg_wdata),
      .raddr(tg_raddr), .rdata(tg_rdata)
   );

endmodule

// File: tb/sim_slot_list_mgr.sv
module sim_slot_list_mgr;
   localparam int NUL = 255;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_op = 3'd0;
   logic [7:0] req_slot = 8'd0, req_data = 8'd0;
   logic       busy, done;
   logic [7:0] result, wait_head, free_head, disc_head;

   int tests = 0, fails = 0;
   int wq[$], fq[$], dq[$];
   int tagm[255];
   bit own[255];

   always #10 clk = ~clk;

   slot_list_mgr #(.IDX_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_slot(req_slot), .req_data(req_data), .busy(busy), .done(done),
      .result(result), .wait_head(wait_head), .free_head(free_head), .disc_head(disc_head)
   );

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int hd(ref int q[$]);
      return (q.size() > 0) ? q[0] : NUL;
   endfunction

   function automatic string op_req(int op, int slot);
      if (slot == NUL && op inside {0, 2, 3, 4, 6}) return "R9";
      case (op)
         0: return "R3";  1: return "R4";  2: return "R5";  3: return "R7";
         4: return "R8";  5: return "R6";  default: return "R10";
      endcase
   endfunction

   // expected result, with the model updated per the requirements
   function automatic int model(int op, int slot, int data);
      int r = NUL;
      case (op)
         0: if (slot != NUL) begin wq.push_front(slot); r = slot; end
         1: if (wq.size() > 0) r = wq.pop_front();
         2: if (slot != NUL) begin fq.push_front(slot); tagm[slot] = NUL; r = slot; end
         3: if (slot != NUL) begin dq.push_front(slot); r = slot; end
         4: if (slot != NUL) begin
               foreach (dq[i]) if (dq[i] == slot) begin dq.delete(i); break; end
               r = slot;
            end
         5: if (fq.size() > 0) r = fq.pop_front();
            else if (dq.size() > 0) r = dq.pop_front();
         6: if (slot != NUL) begin tagm[slot] = data; r = slot; end
         default: r = (slot == NUL) ? NUL : tagm[slot];
      endcase
      return r;
   endfunction

   task automatic issue(int op, int slot, int data, output int res);
      int n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'(op); req_slot = 8'(slot); req_data = 8'(data);
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && n < 50) begin @(negedge clk); n++; end
      if (n >= 50) chk("R2 done timeout", 0, 1);
      res = int'(result);
   endtask

   task automatic run(int op, int slot, int data);
      int res, exp;
      string rq;
      rq = op_req(op, slot);
      exp = model(op, slot, data);
      issue(op, slot, data, res);
      chk({rq, " result"}, res, exp);
      chk({rq, " wait_head"}, int'(wait_head), hd(wq));
      chk({rq, " free_head"}, int'(free_head), hd(fq));
      chk({rq, " disc_head"}, int'(disc_head), hd(dq));
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int res, op, slot, r;
      void'($urandom(32'd2024));
      foreach (tagm[i]) tagm[i] = NUL;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 wait_head", int'(wait_head), NUL);
      chk("R1 free_head", int'(free_head), NUL);
      chk("R1 disc_head", int'(disc_head), NUL);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);

      run(1, 0, 0);            // R4 pop of empty list
      run(5, 0, 0);            // R6 grant with both lists empty
      run(0, NUL, 0);          // R9 null operand
      run(4, NUL, 0);          // R9
      run(6, 5, 8'h3C);        // R10 tag write
      run(7, 5, 0);            // R10 tag read
      run(2, 5, 0);            // R5 free push
      run(7, 5, 0);            // R5 tag now null

      // R2: request held during busy is ignored
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd0; req_slot = 8'd7;
      @(negedge clk);
      chk("R2 busy after accept", int'(busy), 1);
      req_slot = 8'd9;
      r = 0;
      while (!done && r < 50) begin @(negedge clk); r++; end
      chk("R2 result", int'(result), 7);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R2 done one cycle", int'(done), 0);
      @(negedge clk);
      chk("R2 busy request ignored", int'(busy), 0);
      chk("R2 wait_head", int'(wait_head), 7);
      wq.push_front(7); own[7] = 1'b1;

      // R3 LIFO order
      run(0, 3, 0); run(1, 0, 0); run(1, 0, 0); run(1, 0, 0);
      own[7] = 1'b0;

      // R7/R8 disconnected list: head, middle and tail removal
      run(3, 10, 0); run(3, 11, 0); run(3, 12, 0); run(3, 13, 0);
      run(4, 11, 0);           // R8 middle
      run(4, 13, 0);           // R8 head
      run(4, 10, 0);           // R8 tail
      run(3, 20, 0);
      run(5, 0, 0);            // R6 free first (slot 5)
      run(5, 0, 0);            // R6 then disconnected head
      run(5, 0, 0);
      run(5, 0, 0);            // R6 both empty

      // random phase
      for (int k = 0; k < 400; k++) begin
         op = $urandom_range(0, 7);
         slot = $urandom_range(0, 15);
         if (op inside {0, 2, 3} && own[slot]) op = 1;
         if (op == 4) begin
            if (dq.size() == 0) op = 5;
            else slot = dq[$urandom_range(0, dq.size() - 1)];
         end
         if (op == 1 && wq.size() > 0) own[wq[0]] = 1'b0;
         if (op == 5) begin
            if (fq.size() > 0) own[fq[0]] = 1'b0;
            else if (dq.size() > 0) own[dq[0]] = 1'b0;
         end
         if (op == 4) own[slot] = 1'b0;
         if (op inside {0, 2, 3}) own[slot] = 1'b1;
         run(op, slot, $urandom_range(0, 254));
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule